// File: doc/BRIEF.md
# Flag-Setting Arithmetic and Logic Unit

This block computes one of sixteen operations on two data words in a single combinational pass and keeps a four-bit condition register (negative, zero, overflow, carry). A 4-bit function select chooses the operation. Four of the codes are flag-setting forms: they load the condition register at the next rising clock edge. The other twelve codes leave the register alone.

The plain operations are AND, OR, NOR, add, and a logical right shift by a variable amount taken from the low bits of the second operand. There is also a set of fixed helpers that a microcoded sequencer uses to take instruction fields apart and step the program counter. These are two fixed left shifts, zero-extension and sign-extension of a 13-bit immediate, increment by one, increment by the instruction size, and a 5-place right shift that keeps the sign. Choosing the operands and sequencing the microcode are the job of the surrounding datapath.

Top module: `alu16_core`

## Requirements
- R1: Codes 0 and 5 give A AND B. Codes 1 and 6 give A OR B. Codes 2 and 7 give NOT (A OR B).
- R2: Codes 3 and 8 give A + B modulo 2^32.
- R3: Code 4 gives A shifted right logically by B[4:0] places with zeros shifted in. Bits 31:5 of B have no effect.
- R4: Code 9 gives A shifted left by 2 places and code 10 gives A shifted left by 10 places. Zeros fill from the right and bits shifted out of bit 31 are lost.
- R5: Code 11 gives A[12:0] with bits 31:13 cleared. Code 12 gives A[12:0] with bit 12 copied into bits 31:13.
- R6: Code 13 gives A + 1 and code 14 gives A + 4, both modulo 2^32. B has no effect on either.
- R7: Code 15 gives A shifted right by 5 places with bit 31 copied into the vacated bits.
- R8: After a rising edge where the code was 0 to 3 and reset was low, flag_n equals bit 31 of the result and flag_z is 1 exactly when the result was zero.
- R9: After such an edge with code 3, flag_c holds the carry out of bit 31 and flag_v holds the signed two's-complement overflow of the sum. After codes 0 to 2, both flag_c and flag_v are 0.
- R10: A rising edge with a code from 4 to 15 leaves all four flags unchanged.
- R11: A rising edge with rst high clears all four flags, whatever the function code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the condition register |
| rst | input | 1 | Synchronous active-high reset of the flags |
| func | input | 4 | Function select, codes 0 to 15 |
| a | input | 32 | First operand |
| b | input | 32 | Second operand; bits 4:0 are the shift amount for code 4 |
| result | output | 32 | Combinational result |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered overflow flag |
| flag_c | output | 1 | Registered carry flag |

## Verification
The bench builds the block with its default parameters: a 32-bit word, a 13-bit immediate, a +4 step and fixed shifts of 2, 10 and 5. At these values the sign bit of the immediate (bit 12), the full 0 to 31 span of the shift amount, and wraparound at 0xFFFFFFFF can all be reached with hand-computed vectors. The sequences for the flags are chosen so that the carry and overflow sources can be told apart: a signed overflow without carry, a carry without overflow, and both at once. These are followed by logical flag-setting codes, which must clear the carry and overflow flags that the preceding sequences set.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

  typedef enum logic [3:0] {
    FN_ANDF  = 4'd0,
    FN_ORF   = 4'd1,
    FN_NORF  = 4'd2,
    FN_ADDF  = 4'd3,
    FN_SRL   = 4'd4,
    FN_AND   = 4'd5,
    FN_OR    = 4'd6,
    FN_NOR   = 4'd7,
    FN_ADD   = 4'd8,
    FN_SHL_A = 4'd9,
    FN_SHL_B = 4'd10,
    FN_IMMZ  = 4'd11,
    FN_IMMS  = 4'd12,
    FN_INC1  = 4'd13,
    FN_STEP  = 4'd14,
    FN_SRA   = 4'd15
  } alu_fn_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } cc_t;

endpackage

// File: rtl/alu16_shr.sv
// Logical right shifter built from log2(WIDTH) conditional stages.
module alu16_shr #(
  parameter int WIDTH   = 32,
  parameter int SHAMT_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]   din,
  input  logic [SHAMT_W-1:0] amt,
  output logic [WIDTH-1:0]   dout
);

  logic [WIDTH-1:0] stg [0:SHAMT_W];

  assign stg[0] = din;

  for (genvar k = 0; k < SHAMT_W; k++) begin : g_stage
    localparam int DIST = 1 << k;
    assign stg[k+1] = amt[k] ? (stg[k] >> DIST) : stg[k];
  end

  assign dout = stg[SHAMT_W];

endmodule

// File: rtl/alu16_adder.sv
// Single shared adder with carry-out and signed overflow detection.
module alu16_adder #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] x,
  input  logic [WIDTH-1:0] y,
  output logic [WIDTH-1:0] sum,
  output logic             cout,
  output logic             ovf
);

  assign {cout, sum} = {1'b0, x} + {1'b0, y};
  assign ovf = (x[WIDTH-1] == y[WIDTH-1]) && (sum[WIDTH-1] != x[WIDTH-1]);

endmodule

// File: rtl/alu16_ccreg.sv
// Condition register: synchronous reset, loads only when enabled.
module alu16_ccreg
  import alu16_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  cc_t  nxt,
  output cc_t  q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= nxt;
  end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
  import alu16_pkg::*;
#(
  parameter int WIDTH   = 32,
  parameter int IMM_W   = 13,
  parameter int STEP    = 4,
  parameter int SHL_A   = 2,
  parameter int SHL_B   = 10,
  parameter int SRA_N   = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       func,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] result,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v,
  output logic             flag_c
);

  localparam int SHAMT_W = $clog2(WIDTH);
  localparam int EXT_W   = WIDTH - IMM_W;

  alu_fn_e          fn;
  logic [WIDTH-1:0] add_y;
  logic [WIDTH-1:0] add_sum;
  logic             add_cout;
  logic             add_ovf;
  logic [WIDTH-1:0] shr_out;
  logic [WIDTH-1:0] sra_out;
  logic [WIDTH-1:0] res;
  logic             cc_load;
  cc_t              cc_nxt;
  cc_t              cc_q;

  assign fn = alu_fn_e'(func);

  // Operand select for the shared adder: b, +1 or +STEP
  always_comb begin
    unique case (fn)
      FN_INC1: add_y = WIDTH'(1);
      FN_STEP: add_y = WIDTH'(STEP);
      default: add_y = b;
    endcase
  end

  alu16_adder #(.WIDTH(WIDTH)) u_add (
    .x    (a),
    .y    (add_y),
    .sum  (add_sum),
    .cout (add_cout),
    .ovf  (add_ovf)
  );

  alu16_shr #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W)) u_shr (
    .din  (a),
    .amt  (b[SHAMT_W-1:0]),
    .dout (shr_out)
  );

  assign sra_out = WIDTH'($signed(a) >>> SRA_N);

  always_comb begin
    unique case (fn)
      FN_ANDF, FN_AND:   res = a & b;
      FN_ORF,  FN_OR:    res = a | b;
      FN_NORF, FN_NOR:   res = ~(a | b);
      FN_ADDF, FN_ADD,
      FN_INC1, FN_STEP:  res = add_sum;
      FN_SRL:            res = shr_out;
      FN_SHL_A:          res = a << SHL_A;
      FN_SHL_B:          res = a << SHL_B;
      FN_IMMZ:           res = {{EXT_W{1'b0}}, a[IMM_W-1:0]};
      FN_IMMS:           res = {{EXT_W{a[IMM_W-1]}}, a[IMM_W-1:0]};
      FN_SRA:            res = sra_out;
      default:           res = '0;
    endcase
  end

  assign result  = res;
  assign cc_load = (func[3:2] == 2'b00);

  always_comb begin
    cc_nxt.n = res[WIDTH-1];
    cc_nxt.z = (res == '0);
    cc_nxt.v = (fn == FN_ADDF) ? add_ovf  : 1'b0;
    cc_nxt.c = (fn == FN_ADDF) ? add_cout : 1'b0;
  end

  alu16_ccreg u_cc (
    .clk  (clk),
    .rst  (rst),
    .load (cc_load),
    .nxt  (cc_nxt),
    .q    (cc_q)
  );

  assign flag_n = cc_q.n;
  assign flag_z = cc_q.z;
  assign flag_v = cc_q.v;
  assign flag_c = cc_q.c;

endmodule

// File: rtl/alu16_core_chk.sv
module alu16_core_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       func,
  input logic [WIDTH-1:0] result,
  input logic             flag_n,
  input logic             flag_z,
  input logic             flag_v,
  input logic             flag_c
);

  AST_CC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (func >= 4'd4) |=> $stable({flag_n, flag_z, flag_v, flag_c})); // R10

  AST_LOGIC_CV_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (func <= 4'd2) |=> (!flag_c && !flag_v)); // R9

  AST_ZERO_TRACK: assert property (@(posedge clk) disable iff (rst)
    (func <= 4'd3) |=> (flag_z == $past(result == '0))); // R8

  AST_NEG_TRACK: assert property (@(posedge clk) disable iff (rst)
    (func <= 4'd3) |=> (flag_n == $past(result[WIDTH-1]))); // R8

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> ({flag_n, flag_z, flag_v, flag_c} == 4'b0000)); // R11

endmodule

bind alu16_core alu16_core_chk #(.WIDTH(WIDTH)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .func   (func),
  .result (result),
  .flag_n (flag_n),
  .flag_z (flag_z),
  .flag_v (flag_v),
  .flag_c (flag_c)
);

// File: tb/alu16_core_bench.sv
`timescale 1ns/1ps
module alu16_core_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  func;
  logic [31:0] a;
  logic [31:0] b;
  logic [31:0] result;
  logic        flag_n, flag_z, flag_v, flag_c;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  alu16_core u_alu16_core (
    .clk    (clk),
    .rst    (rst),
    .func   (func),
    .a      (a),
    .b      (b),
    .result (result),
    .flag_n (flag_n),
    .flag_z (flag_z),
    .flag_v (flag_v),
    .flag_c (flag_c)
  );

  typedef struct packed {
    logic [3:0]  f;
    logic [31:0] x;
    logic [31:0] y;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VT [0:NV-1] = '{
    '{4'd0,  32'hF0F0_F0F0, 32'hFF00_FF00, 32'hF000_F000}, // R1
    '{4'd1,  32'hF0F0_0000, 32'h0F00_00FF, 32'hFFF0_00FF}, // R1
    '{4'd2,  32'h0000_FFFF, 32'h00FF_0000, 32'hFF00_0000}, // R1
    '{4'd3,  32'h7FFF_FFFF, 32'h0000_0001, 32'h8000_0000}, // R2
    '{4'd4,  32'h8000_0000, 32'h0000_001F, 32'h0000_0001}, // R3
    '{4'd4,  32'hF000_000F, 32'hFFFF_FFE4, 32'h0F00_0000}, // R3 upper b ignored
    '{4'd4,  32'h1234_5678, 32'hFFFF_FFE0, 32'h1234_5678}, // R3 zero amount
    '{4'd5,  32'h1234_5678, 32'h0F0F_0F0F, 32'h0204_0608}, // R1
    '{4'd6,  32'h1200_0034, 32'h0045_6700, 32'h1245_6734}, // R1
    '{4'd7,  32'hFFFF_0000, 32'h0000_FF00, 32'h0000_00FF}, // R1
    '{4'd8,  32'hFFFF_FFFF, 32'h0000_0002, 32'h0000_0001}, // R2 wrap
    '{4'd9,  32'hC000_0001, 32'hDEAD_BEEF, 32'h0000_0004}, // R4
    '{4'd10, 32'h003F_FFFF, 32'hDEAD_BEEF, 32'hFFFF_FC00}, // R4
    '{4'd11, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0000_1FFF}, // R5
    '{4'd11, 32'h0000_0ABC, 32'h0000_0000, 32'h0000_0ABC}, // R5
    '{4'd12, 32'h0000_1000, 32'hDEAD_BEEF, 32'hFFFF_F000}, // R5
    '{4'd12, 32'hFFFF_0FFF, 32'h0000_0000, 32'h0000_0FFF}, // R5
    '{4'd13, 32'hFFFF_FFFF, 32'hDEAD_BEEF, 32'h0000_0000}, // R6
    '{4'd13, 32'h0000_0010, 32'h0000_0100, 32'h0000_0011}, // R6
    '{4'd14, 32'hFFFF_FFFE, 32'hDEAD_BEEF, 32'h0000_0002}, // R6
    '{4'd14, 32'h0000_0100, 32'h0000_0000, 32'h0000_0104}, // R6
    '{4'd15, 32'h8000_0000, 32'hDEAD_BEEF, 32'hFC00_0000}, // R7
    '{4'd15, 32'h7FFF_FFE0, 32'h0000_0000, 32'h03FF_FFFF}, // R7
    '{4'd15, 32'hFFFF_FFE0, 32'h0000_0000, 32'hFFFF_FFFF}  // R7
  };

  function automatic string req_of(input logic [3:0] f);
    case (f)
      4'd0, 4'd1, 4'd2, 4'd5, 4'd6, 4'd7: return "R1";
      4'd3, 4'd8:                         return "R2";
      4'd4:                               return "R3";
      4'd9, 4'd10:                        return "R4";
      4'd11, 4'd12:                       return "R5";
      4'd13, 4'd14:                       return "R6";
      default:                            return "R7";
    endcase
  endfunction

  task automatic chk_word(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_cc(input string req, input logic [3:0] exp);
    checks++;
    if ({flag_n, flag_z, flag_v, flag_c} !== exp) begin
      errors++;
      $display("FAIL %s: nzvc got %b expected %b", req,
               {flag_n, flag_z, flag_v, flag_c}, exp);
    end
  endtask

  // Drive at a falling edge, pass one rising edge, return at the next falling edge.
  task automatic step(input logic [3:0] f, input logic [31:0] x, input logic [31:0] y);
    func = f;
    a    = x;
    b    = y;
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst  = 1'b1;
    func = 4'd0;
    a    = '0;
    b    = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_cc("R11", 4'b0000);
    rst = 1'b0;

    // Vector table: combinational result
    for (int i = 0; i < NV; i++) begin
      func = VT[i].f;
      a    = VT[i].x;
      b    = VT[i].y;
      #1;
      chk_word(req_of(VT[i].f), result, VT[i].exp);
      @(negedge clk);
    end

    // Flag behaviour, nzvc order
    step(4'd3, 32'h7FFF_FFFF, 32'h0000_0001);
    chk_cc("R9", 4'b1010);   // overflow without carry
    step(4'd3, 32'hFFFF_FFFF, 32'h0000_0001);
    chk_cc("R9", 4'b0101);   // carry without overflow, zero
    step(4'd3, 32'h8000_0000, 32'h8000_0000);
    chk_cc("R9", 4'b0111);   // both, zero

    for (int f = 4; f < 16; f++) begin
      step(4'(f), 32'h8000_0000, 32'h0000_0000);
      chk_cc("R10", 4'b0111);
    end

    step(4'd0, 32'hFFFF_FFFF, 32'h0000_0000);
    chk_cc("R9", 4'b0100);   // logical clears v and c
    step(4'd1, 32'h8000_0000, 32'h0000_0000);
    chk_cc("R8", 4'b1000);
    step(4'd2, 32'h0000_0000, 32'h0000_0000);
    chk_cc("R8", 4'b1000);
    step(4'd2, 32'hFFFF_FFFF, 32'h0000_0000);
    chk_cc("R8", 4'b0100);

    // Reset overrides a flag-setting code
    step(4'd3, 32'h7FFF_FFFF, 32'h0000_0001);
    chk_cc("R8", 4'b1010);
    rst = 1'b1;
    step(4'd3, 32'h8000_0000, 32'h8000_0000);
    chk_cc("R11", 4'b0000);
    rst = 1'b0;
    step(4'd8, 32'h8000_0000, 32'h8000_0000);
    chk_cc("R10", 4'b0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule